// File: doc/BRIEF.md
# Round-Robin Crossbar Matching Scheduler

This block decides, once per timeslot, which input of an N-by-N crossbar is connected to which output. It reads a square request matrix in which each set bit says that an input holds at least one packet for an output, as per-output queues at each input would report. From that matrix it builds a one-to-one match: no input drives two outputs and no output listens to two inputs.

The match is built by repeated rounds. In each round every output that is still free offers itself to one of the free inputs that want it. Every free input that received offers then takes one of them. Both choices follow rotating round-robin pointers rather than random draws. A single round can leave pairs that could still be joined, so the block runs a parameter-set number of rounds, one per clock, and adds each round's new pairs to the match. A start pulse opens a timeslot. A one-cycle done pulse marks the cycle in which the final match is on the output. The match then stays there until the next start.

Top module: `rr_match_sched`

## Requirements
- R1: Request bit `i*N+j` set means input i holds traffic for output j, and match bit `i*N+j` uses the same position; a match bit is only ever set where the latched request bit is set, and an all-zero request gives an all-zero match.
- R2: Within a match, each input row and each output column holds at most one set bit.
- R3: In every round, each output that is still unmatched grants the first unmatched requesting input found by scanning upward from its grant pointer and wrapping from N-1 to 0.
- R4: In every round, each input that is still unmatched and holds grants accepts the first granting output found by scanning upward from its accept pointer and wrapping; the accepted pairs join the match.
- R5: A grant pointer moves to one past the input it granted, and an accept pointer to one past the output it accepted (wrapping to 0), only when that grant is accepted in the first round of a timeslot; otherwise pointers hold.
- R6: Inputs and outputs paired in an earlier round of the same timeslot take no part in later rounds, and later rounds only add pairs.
- R7: A start pulse while idle latches the request matrix and clears the match; request changes after that edge have no effect on the timeslot.
- R8: done is high for exactly one cycle, ITERS cycles after the clock edge that accepted start; the match on that cycle is final and holds until the next accepted start.
- R9: A start pulse while rounds are still running is ignored.
- R10: After reset the match is zero, done is low and all grant and accept pointers are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Opens a timeslot when the block is idle |
| req | input | N*N | Request matrix, bit i*N+j for input i to output j |
| match | output | N*N | Match matrix, same bit layout as req |
| done | output | 1 | One-cycle pulse when the match is final |

## Verification
A grant or accept pointer left in the wrong place does not break the one-to-one shape of the match. Instead it shows up as a different but still legal set of pairs, usually in the first timeslot where the stale pointer meets a contended column or row. The bench therefore compares every match bit for bit against an independent model that carries its own pointers across thousands of timeslots, so pointer drift shows within a slot or two. A wrong round counter or busy flag shows at once as done arriving in the wrong cycle, or as the match changing after done.

// File: rtl/rrm_pkg.sv
package rrm_pkg;

   // Variant of the round-robin pick circuit
   typedef enum logic [0:0] {
      PICK_SCAN = 1'b0,   // rotating priority scan
      PICK_MASK = 1'b1    // masked upper half, then wrap
   } pick_style_e;

   // Bits needed to hold an index below n (at least one)
   function automatic int ptr_bits(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/rrm_rr_pick.sv
module rrm_rr_pick #(
   parameter int                  N     = 4,
   parameter rrm_pkg::pick_style_e STYLE = rrm_pkg::PICK_MASK,
   localparam int                 PW    = rrm_pkg::ptr_bits(N)
) (
   input  logic [N-1:0]  req,
   input  logic [PW-1:0] ptr,
   output logic [N-1:0]  gnt,
   output logic [PW-1:0] idx
);

   if (N < 2) begin : g_bad_n
      $error("rrm_rr_pick: N must be at least 2");
   end

   if (STYLE == rrm_pkg::PICK_SCAN) begin : g_scan
      always_comb begin
         gnt = '0;
         for (int k = 0; k < N; k++) begin
            if (req[(int'(ptr) + k) % N] && (gnt == '0)) begin
               gnt[(int'(ptr) + k) % N] = 1'b1;
            end
         end
      end
   end else begin : g_mask
      logic [N-1:0] upper;
      logic [N-1:0] hi;
      logic [N-1:0] hi_low;
      logic [N-1:0] all_low;
      always_comb begin
         for (int k = 0; k < N; k++) begin
            upper[k] = (k >= int'(ptr));
         end
      end
      assign hi      = req & upper;
      assign hi_low  = hi & (~hi + 1'b1);
      assign all_low = req & (~req + 1'b1);
      assign gnt     = (|hi) ? hi_low : all_low;
   end

   always_comb begin
      idx = '0;
      for (int k = 0; k < N; k++) begin
         if (gnt[k]) idx = idx | PW'(k);
      end
   end

endmodule

// File: rtl/rrm_stage.sv
module rrm_stage #(
   parameter int                  N      = 4,
   parameter rrm_pkg::pick_style_e STYLE  = rrm_pkg::PICK_MASK,
   parameter bit                  BY_COL = 1'b1,
   localparam int                 PW     = rrm_pkg::ptr_bits(N),
   localparam int                 NN     = N * N
) (
   input  logic [NN-1:0]         mat,
   input  logic [N-1:0][PW-1:0]  ptr,
   output logic [NN-1:0]         pick_mat,
   output logic [N-1:0][PW-1:0]  pick_idx
);

   // One arbiter per lane: a lane is an output column (BY_COL) or an input row
   for (genvar l = 0; l < N; l++) begin : g_lane
      logic [N-1:0] vec;
      logic [N-1:0] sel;
      for (genvar m = 0; m < N; m++) begin : g_mem
         if (BY_COL) begin : g_col
            assign vec[m]            = mat[m*N + l];
            assign pick_mat[m*N + l] = sel[m];
         end else begin : g_row
            assign vec[m]            = mat[l*N + m];
            assign pick_mat[l*N + m] = sel[m];
         end
      end
      rrm_rr_pick #(.N(N), .STYLE(STYLE)) u_pick (
         .req (vec),
         .ptr (ptr[l]),
         .gnt (sel),
         .idx (pick_idx[l])
      );
   end

endmodule

// File: rtl/rrm_ctrl.sv
module rrm_ctrl #(
   parameter int  ITERS = 2,
   localparam int CW    = (ITERS < 2) ? 1 : $clog2(ITERS)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic busy,
   output logic first,
   output logic done
);

   if (ITERS < 1) begin : g_bad_iters
      $error("rrm_ctrl: ITERS must be at least 1");
   end

   logic [CW-1:0] cnt;
   logic          last;

   assign load  = start & ~busy;
   assign first = busy & (cnt == '0);
   assign last  = busy & (cnt == CW'(ITERS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (load) begin
            busy <= 1'b1;
            cnt  <= '0;
         end else if (busy) begin
            if (last) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/rr_match_sched.sv
module rr_match_sched #(
   parameter int                  N     = 4,
   parameter int                  ITERS = rrm_pkg::ptr_bits(N),
   parameter rrm_pkg::pick_style_e STYLE = rrm_pkg::PICK_MASK,
   localparam int                 PW    = rrm_pkg::ptr_bits(N),
   localparam int                 NN    = N * N
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [NN-1:0] req,
   output logic [NN-1:0] match,
   output logic          done
);

   if (N < 2) begin : g_bad_n
      $error("rr_match_sched: N must be at least 2");
   end
   if (ITERS < 1) begin : g_bad_iters
      $error("rr_match_sched: ITERS must be at least 1");
   end

   logic                 load;
   logic                 busy;
   logic                 first;
   logic [NN-1:0]        req_q;
   logic [NN-1:0]        match_q;
   logic [N-1:0]         in_taken;
   logic [N-1:0]         out_taken;
   logic [NN-1:0]        elig;
   logic [NN-1:0]        grant;
   logic [NN-1:0]        acc;
   logic [N-1:0]         in_acc;
   logic [N-1:0]         out_acc;
   logic [N-1:0][PW-1:0] gptr;
   logic [N-1:0][PW-1:0] aptr;
   logic [N-1:0][PW-1:0] gidx;
   logic [N-1:0][PW-1:0] aidx;

   rrm_ctrl #(.ITERS(ITERS)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .load  (load),
      .busy  (busy),
      .first (first),
      .done  (done)
   );

   // Rows and columns already paired in this timeslot
   always_comb begin
      in_taken  = '0;
      out_taken = '0;
      for (int i = 0; i < N; i++) begin
         for (int j = 0; j < N; j++) begin
            if (match_q[i*N + j]) begin
               in_taken[i]  = 1'b1;
               out_taken[j] = 1'b1;
            end
         end
      end
   end

   always_comb begin
      for (int i = 0; i < N; i++) begin
         for (int j = 0; j < N; j++) begin
            elig[i*N + j] = req_q[i*N + j] & ~in_taken[i] & ~out_taken[j];
         end
      end
   end

   // Grant: one arbiter per output column
   rrm_stage #(.N(N), .STYLE(STYLE), .BY_COL(1'b1)) u_grant (
      .mat      (elig),
      .ptr      (gptr),
      .pick_mat (grant),
      .pick_idx (gidx)
   );

   // Accept: one arbiter per input row
   rrm_stage #(.N(N), .STYLE(STYLE), .BY_COL(1'b0)) u_accept (
      .mat      (grant),
      .ptr      (aptr),
      .pick_mat (acc),
      .pick_idx (aidx)
   );

   always_comb begin
      in_acc  = '0;
      out_acc = '0;
      for (int i = 0; i < N; i++) begin
         for (int j = 0; j < N; j++) begin
            if (acc[i*N + j]) begin
               in_acc[i]  = 1'b1;
               out_acc[j] = 1'b1;
            end
         end
      end
   end

   // Pointers move only on first-round acceptances
   for (genvar l = 0; l < N; l++) begin : g_ptr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            gptr[l] <= '0;
         end else if (first && out_acc[l]) begin
            gptr[l] <= (gidx[l] == PW'(N - 1)) ? '0 : gidx[l] + 1'b1;
         end
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            aptr[l] <= '0;
         end else if (first && in_acc[l]) begin
            aptr[l] <= (aidx[l] == PW'(N - 1)) ? '0 : aidx[l] + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q   <= '0;
         match_q <= '0;
      end else if (load) begin
         req_q   <= req;
         match_q <= '0;
      end else if (busy) begin
         match_q <= match_q | acc;
      end
   end

   assign match = match_q;

endmodule

// File: rtl/rrm_chk.sv
module rrm_chk #(
   parameter int  N     = 4,
   parameter int  ITERS = 2,
   localparam int NN    = N * N,
   localparam int CW    = $clog2(ITERS + 2)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic          done,
   input logic [NN-1:0] req_q,
   input logic [NN-1:0] match
);

   logic          rows_ok;
   logic          cols_ok;
   logic [CW-1:0] cyc;

   always_comb begin
      rows_ok = 1'b1;
      cols_ok = 1'b1;
      for (int a = 0; a < N; a++) begin
         logic [N-1:0] row;
         logic [N-1:0] col;
         for (int b = 0; b < N; b++) begin
            row[b] = match[a*N + b];
            col[b] = match[b*N + a];
         end
         if ($countones(row) > 1) rows_ok = 1'b0;
         if ($countones(col) > 1) cols_ok = 1'b0;
      end
   end

   // Rounds since the accepted start
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cyc <= '0;
      else if (start && !busy) cyc <= '0;
      else if (busy)           cyc <= cyc + 1'b1;
   end

   a_r1_subset: assert property (@(posedge clk) disable iff (!rst_n)
      (match & ~req_q) == '0);

   a_r2_one_per_row: assert property (@(posedge clk) disable iff (!rst_n)
      rows_ok);

   a_r2_one_per_col: assert property (@(posedge clk) disable iff (!rst_n)
      cols_ok);

   a_r6_only_adds: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ((match & $past(match)) == $past(match)));

   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r8_done_timing: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cyc == CW'(ITERS)));

   a_r8_match_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(match));

   a_r9_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(req_q));

endmodule

bind rr_match_sched rrm_chk #(.N(N), .ITERS(ITERS)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .start (start),
   .busy  (busy),
   .done  (done),
   .req_q (req_q),
   .match (match)
);

// File: tb/sim_rr_match_sched.sv
module sim_rr_match_sched;

   localparam int N  = 4;
   localparam int IT = 2;
   localparam int NN = N * N;

   logic          clk   = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [NN-1:0] req   = '0;
   logic [NN-1:0] m0, m1;
   logic          d0, d1;

   int n_chk = 0;
   int n_bad = 0;
   int gp [N];
   int ap [N];
   logic [31:0] seed = 32'h1234_5678;

   always #10 clk = ~clk;

   rr_match_sched #(.N(N), .ITERS(IT), .STYLE(rrm_pkg::PICK_MASK)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .req(req), .match(m0), .done(d0));

   rr_match_sched #(.N(N), .ITERS(IT), .STYLE(rrm_pkg::PICK_SCAN)) u1 (
      .clk(clk), .rst_n(rst_n), .start(start), .req(req), .match(m1), .done(d1));

   task automatic chk(input bit ok, input string rq, input logic [NN-1:0] act,
                      input logic [NN-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   function automatic bit row_used(input logic [NN-1:0] m, input int i);
      return |m[i*N +: N];
   endfunction

   function automatic bit col_used(input logic [NN-1:0] m, input int o);
      bit u = 1'b0;
      for (int i = 0; i < N; i++) u |= m[i*N + o];
      return u;
   endfunction

   function automatic bit shape_ok(input logic [NN-1:0] m);
      bit ok = 1'b1;
      for (int a = 0; a < N; a++) begin
         int rc = 0;
         int cc = 0;
         for (int b = 0; b < N; b++) begin
            rc += m[a*N + b];
            cc += m[b*N + a];
         end
         if (rc > 1 || cc > 1) ok = 1'b0;
      end
      return ok;
   endfunction

   // Reference: rounds of grant then accept, pointers kept here
   task automatic model(input logic [NN-1:0] r, output logic [NN-1:0] m);
      int g [N];
      m = '0;
      for (int it = 0; it < IT; it++) begin
         logic [NN-1:0] add = '0;
         for (int o = 0; o < N; o++) begin
            g[o] = -1;
            if (!col_used(m, o)) begin
               for (int k = 0; k < N; k++) begin
                  int i = (gp[o] + k) % N;
                  if (g[o] < 0 && r[i*N + o] && !row_used(m, i)) g[o] = i;
               end
            end
         end
         for (int i = 0; i < N; i++) begin
            int a0 = ap[i];
            int pick = -1;
            for (int k = 0; k < N; k++) begin
               int o = (a0 + k) % N;
               if (pick < 0 && g[o] == i) pick = o;
            end
            if (pick >= 0) begin
               add[i*N + pick] = 1'b1;
               if (it == 0) begin
                  gp[pick] = (i + 1) % N;
                  ap[i]    = (pick + 1) % N;
               end
            end
         end
         m = m | add;
      end
   endtask

   task automatic run_slot(input logic [NN-1:0] r, input bit bs, input string tag,
                           output logic [NN-1:0] got);
      logic [NN-1:0] e;
      bit tim_ok = 1'b1;
      model(r, e);
      @(negedge clk);
      req   = r;
      start = 1'b1;
      for (int c = 1; c <= IT; c++) begin
         @(negedge clk);
         start = bs && (c == 1);   // R9: start while busy
         req   = ~r ^ NN'(c);      // R7: late request changes
         if (d0 || d1) tim_ok = 1'b0;
      end
      @(negedge clk);
      start = 1'b0;
      if (!(d0 && d1)) tim_ok = 1'b0;
      chk(tim_ok, {"R8 done timing ", tag}, NN'(d0), NN'(1));
      chk(m0 == e, {"R3 R4 R5 R6 match ", tag}, m0, e);
      chk(m1 == e, {"R3 R4 R5 R6 scan variant ", tag}, m1, e);
      chk(shape_ok(m0) && ((m0 & ~r) == '0), {"R1 R2 shape ", tag}, m0, e);
      got = m0;
      @(negedge clk);
      chk(!d0 && !d1 && m0 == e && m1 == e, {"R8 held after done ", tag}, m0, e);
   endtask

   initial begin
      logic [NN-1:0] got;
      for (int k = 0; k < N; k++) begin
         gp[k] = 0;
         ap[k] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(m0 == '0 && m1 == '0 && !d0 && !d1, "R10 reset state", m0, '0);

      // Fresh pointers: all outputs grant input 0, second round pairs 1 with 1
      run_slot('1, 1'b0, "full first", got);
      chk(got == 16'h0021, "R10 R3 R4 pointers start at zero", got, 16'h0021);
      // First-round moves only: expect (0,1) (1,0) (2,2)
      run_slot('1, 1'b0, "full second", got);
      chk(got == 16'h0412, "R5 R6 pointer advance", got, 16'h0412);

      run_slot('0, 1'b0, "empty", got);
      chk(got == '0, "R1 empty request", got, '0);

      run_slot(16'h8421, 1'b1, "R7 R9 busy start", got);

      for (int b = 0; b < NN; b++) begin
         run_slot(NN'(1) << b, 1'b0, "R1 single bit", got);
      end

      for (int s = 0; s < 3000; s++) begin
         logic [NN-1:0] r;
         seed = seed * 32'd1103515245 + 32'd12345;
         r = seed[23:8];
         if (s % 3 == 1) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            r = r & seed[27:12];
         end
         run_slot(r, (s % 7) == 0, "sweep", got);
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R8 run did not finish actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule